// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This block sits beside an 8-bit microcontroller core and decides which of seven interrupt sources the core serves next. Software programs three 8-bit registers over a simple write/read bus: an enable register with a global gate, and two priority-bit registers. For each source, its bit in the two priority registers together gives a 2-bit level. Level 0 is the lowest and level 3 the highest. The block latches requests from two active-low external pins, two timer overflow pulses, and three request lines whose flags live in their own peripherals (serial port, timer 2, counter array). Each external pin can detect either a falling edge or a low level.

When an enabled request outranks everything in service, the block raises a one-cycle vector strobe with an 8-bit vector address. It then waits for the core's acknowledge. On that acknowledge it clears any flag that hardware is allowed to clear, and it marks the winning level as in service. Four in-service bits form a nesting stack, so only a strictly higher level can preempt a running handler. A return pulse from the core pops the highest in-service level, and the preempted handler's level becomes active again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all three registers read 0, no flag is pending, `vecReq` is 0 and `inService` is 0.
- R2: Register address 0 is the enable register, 1 is the low priority bits and 2 is the high priority bits. Writes take effect on the next clock edge and read back at once. Address 3 reads 0, and bit 7 of both priority registers reads 0.
- R3: Source index bits (same position in all three registers): 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2, 6 counter array. Enable bit 7 is a global gate. With bit 7 at 0 no vector is issued, and with bit 7 at 1 a source needs its own enable bit set.
- R4: A source's level is {high bit, low bit}. The eligible source with the highest level wins whatever its position in polling order.
- R5: Among eligible sources at the same level, the first in this polling order wins: external 0, timer 0, external 1, timer 1, counter array, serial, timer 2.
- R6: The vector address is 8 × source index + 3 (03h, 0Bh, 13h, 1Bh, 23h, 2Bh, 33h).
- R7: `vecReq` is high for exactly one cycle. No further strobe comes until `vecAck` has been seen.
- R8: `vecAck` sets the `inService` bit of the issued level. `retiPulse` clears only the highest set bit, and `activeLevel` shows the highest set bit.
- R9: While any level is in service, a request at an equal or lower level waits. A request at a strictly higher level is vectored at once.
- R10: In edge mode, a 1-to-0 transition on an external pin sets its flag, which stays set after the pin returns high and is cleared by the acknowledge. In level mode, the flag follows the inverted pin and the acknowledge does not clear it.
- R11: A timer overflow pulse sets its flag and the acknowledge clears it. Serial, timer 2 and counter-array flags follow their request inputs and the acknowledge does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` |
| extInN | input | 2 | Active-low external interrupt pins (bit 0 external 0) |
| extEdgeMode | input | 2 | 1 selects falling-edge detection for that pin |
| tmrOvf | input | 2 | Overflow pulses of timer 0 (bit 0) and timer 1 |
| serReq | input | 1 | Serial port request flag |
| tmr2Req | input | 1 | Timer 2 request flag |
| pcaReq | input | 1 | Counter array request flag |
| vecReq | output | 1 | One-cycle vector strobe |
| vecAddr | output | 8 | Vector address of the issued source |
| vecAck | input | 1 | Core acknowledge of the vector |
| retiPulse | input | 1 | Return-from-interrupt pulse |
| inService | output | 4 | In-service bit per level |
| activeLevel | output | 2 | Highest level in service |
| pendFlags | output | 7 | Pending flag per source index |

## Verification
The arbiter is tried with pending sets that separate its ordering rules. One set puts two sources at different levels with polling order against the level, so a level-blind design fails. Another ties two sources on one level where index order and polling order disagree (counter array against serial). Nesting is run with a same-level request and then a higher-level request while a handler is active, which tells "wait" from "preempt". The external pins are driven in both detection modes and the flags are read after the acknowledge, which tells hardware-cleared sources from software-cleared ones.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NUM_SRC = 7;
  localparam int NUM_LVL = 4;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int DATA_W  = 8;
  localparam int GLOBAL_EN_BIT = DATA_W - 1;

  localparam int SRC_EXT0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_TMR1 = 3;
  localparam int SRC_SER  = 4;
  localparam int SRC_TMR2 = 5;
  localparam int SRC_PCA  = 6;

  typedef struct packed {
    logic             ackClr;
    logic [SRC_W-1:0] ackSrc;
    logic [LVL_W-1:0] ackLvl;
    logic             retire;
  } ctrlStrobeT;

  // Fixed polling order used to break ties within one level
  function automatic logic [SRC_W-1:0] pollSrc(input int k);
    case (k)
      0:       return SRC_W'(SRC_EXT0);
      1:       return SRC_W'(SRC_TMR0);
      2:       return SRC_W'(SRC_EXT1);
      3:       return SRC_W'(SRC_TMR1);
      4:       return SRC_W'(SRC_PCA);
      5:       return SRC_W'(SRC_SER);
      default: return SRC_W'(SRC_TMR2);
    endcase
  endfunction
endpackage

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic [1:0]                    regAddr,
  input  logic [DATA_W-1:0]             regWrData,
  output logic [DATA_W-1:0]             regRdData,
  input  logic [1:0]                    extInN,
  input  logic [1:0]                    extEdgeMode,
  input  logic [1:0]                    tmrOvf,
  input  logic                          serReq,
  input  logic                          tmr2Req,
  input  logic                          pcaReq,
  input  ctrlStrobeT                    strb,
  output logic [NUM_SRC-1:0]            eligMask,
  output logic [NUM_SRC-1:0][LVL_W-1:0] srcLvl,
  output logic [NUM_LVL-1:0]            inService,
  output logic [LVL_W-1:0]              activeLevel,
  output logic                          anyActive,
  output logic [NUM_SRC-1:0]            pendFlags,
  output logic                          globalEn
);
  localparam int EXT_CNT = 2;

  logic [DATA_W-1:0]  enReg;
  logic [NUM_SRC-1:0] prioLo, prioHi;
  logic [NUM_SRC-1:0] flags;
  logic [NUM_LVL-1:0] isr, isrNext;
  logic [EXT_CNT-1:0] extD1, extD2, extFall;

  // Register bus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= '0;
      prioLo <= '0;
      prioHi <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        2'd0: enReg  <= regWrData;
        2'd1: prioLo <= regWrData[NUM_SRC-1:0];
        2'd2: prioHi <= regWrData[NUM_SRC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      2'd0:    regRdData = enReg;
      2'd1:    regRdData = DATA_W'(prioLo);
      2'd2:    regRdData = DATA_W'(prioHi);
      default: regRdData = '0;
    endcase
  end

  // External pin sampling, falling edge seen across two samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extD1 <= '1;
      extD2 <= '1;
    end else begin
      extD1 <= extInN;
      extD2 <= extD1;
    end
  end
  assign extFall = extD2 & ~extD1;

  function automatic logic ackHits(input ctrlStrobeT s, input int idx);
    return s.ackClr && (s.ackSrc == SRC_W'(idx));
  endfunction

  // Request flags
  genvar g;
  generate
    for (g = 0; g < EXT_CNT; g++) begin : gExt
      localparam int IDX = (g == 0) ? SRC_EXT0 : SRC_EXT1;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  flags[IDX] <= 1'b0;
        else if (!extEdgeMode[g])   flags[IDX] <= ~extD1[g];
        else if (extFall[g])        flags[IDX] <= 1'b1;
        else if (ackHits(strb, IDX)) flags[IDX] <= 1'b0;
      end
    end
    for (g = 0; g < 2; g++) begin : gTmr
      localparam int IDX = (g == 0) ? SRC_TMR0 : SRC_TMR1;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   flags[IDX] <= 1'b0;
        else if (tmrOvf[g])          flags[IDX] <= 1'b1;
        else if (ackHits(strb, IDX)) flags[IDX] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags[SRC_SER]  <= 1'b0;
      flags[SRC_TMR2] <= 1'b0;
      flags[SRC_PCA]  <= 1'b0;
    end else begin
      flags[SRC_SER]  <= serReq;
      flags[SRC_TMR2] <= tmr2Req;
      flags[SRC_PCA]  <= pcaReq;
    end
  end

  // In-service stack
  always_comb begin
    logic popped;
    isrNext = isr;
    popped  = 1'b0;
    if (strb.retire) begin
      for (int i = NUM_LVL - 1; i >= 0; i--) begin
        if (!popped && isr[i]) begin
          isrNext[i] = 1'b0;
          popped     = 1'b1;
        end
      end
    end
    if (strb.ackClr) isrNext[strb.ackLvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) isr <= '0;
    else       isr <= isrNext;
  end

  always_comb begin
    activeLevel = '0;
    for (int i = 0; i < NUM_LVL; i++)
      if (isr[i]) activeLevel = LVL_W'(i);
  end

  generate
    for (g = 0; g < NUM_SRC; g++) begin : gLvl
      assign srcLvl[g] = {prioHi[g], prioLo[g]};
    end
  endgenerate

  assign globalEn  = enReg[GLOBAL_EN_BIT];
  assign eligMask  = flags & enReg[NUM_SRC-1:0] & {NUM_SRC{globalEn}};
  assign inService = isr;
  assign anyActive = |isr;
  assign pendFlags = flags;
endmodule

// File: rtl/prio_irq_control.sv
module prio_irq_control
  import prio_irq_pkg::*;
#(
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SRC-1:0]            eligMask,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] srcLvl,
  input  logic                          anyActive,
  input  logic [LVL_W-1:0]              activeLevel,
  input  logic                          vecAck,
  input  logic                          retiPulse,
  output ctrlStrobeT                    strb,
  output logic                          vecReq,
  output logic [DATA_W-1:0]             vecAddr,
  output logic [LVL_W-1:0]              issuedLvl
);
  typedef enum logic {ST_IDLE, ST_WAIT} stateT;

  stateT            state;
  logic             winValid;
  logic [SRC_W-1:0] winSrc, issuedSrc;
  logic [LVL_W-1:0] winLvl;

  // Highest level first, earliest in polling order on a tie
  always_comb begin
    winValid = 1'b0;
    winSrc   = '0;
    winLvl   = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      logic [SRC_W-1:0] s;
      logic             cand;
      s    = pollSrc(k);
      cand = eligMask[s] && (!anyActive || (srcLvl[s] > activeLevel));
      if (cand && (!winValid || (srcLvl[s] > winLvl))) begin
        winValid = 1'b1;
        winSrc   = s;
        winLvl   = srcLvl[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      vecReq    <= 1'b0;
      vecAddr   <= '0;
      issuedSrc <= '0;
      issuedLvl <= '0;
    end else begin
      vecReq <= 1'b0;
      case (state)
        ST_IDLE: if (winValid) begin
          vecReq    <= 1'b1;
          vecAddr   <= DATA_W'(VEC_BASE + int'(winSrc) * VEC_STRIDE);
          issuedSrc <= winSrc;
          issuedLvl <= winLvl;
          state     <= ST_WAIT;
        end
        default: if (vecAck) state <= ST_IDLE;
      endcase
    end
  end

  assign strb.ackClr = (state == ST_WAIT) && vecAck;
  assign strb.ackSrc = issuedSrc;
  assign strb.ackLvl = issuedLvl;
  assign strb.retire = retiPulse;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic [1:0]  extInN,
  input  logic [1:0]  extEdgeMode,
  input  logic [1:0]  tmrOvf,
  input  logic        serReq,
  input  logic        tmr2Req,
  input  logic        pcaReq,
  output logic        vecReq,
  output logic [7:0]  vecAddr,
  input  logic        vecAck,
  input  logic        retiPulse,
  output logic [3:0]  inService,
  output logic [1:0]  activeLevel,
  output logic [6:0]  pendFlags
);
  ctrlStrobeT                    strb;
  logic [NUM_SRC-1:0]            eligMask;
  logic [NUM_SRC-1:0][LVL_W-1:0] srcLvl;
  logic                          anyActive;
  logic                          globalEn;
  logic [LVL_W-1:0]              issuedLvl;

  prio_irq_datapath uDp (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .extInN(extInN), .extEdgeMode(extEdgeMode), .tmrOvf(tmrOvf),
    .serReq(serReq), .tmr2Req(tmr2Req), .pcaReq(pcaReq),
    .strb(strb), .eligMask(eligMask), .srcLvl(srcLvl),
    .inService(inService), .activeLevel(activeLevel), .anyActive(anyActive),
    .pendFlags(pendFlags), .globalEn(globalEn)
  );

  prio_irq_control #(.VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) uCtl (
    .clk(clk), .rstN(rstN),
    .eligMask(eligMask), .srcLvl(srcLvl),
    .anyActive(anyActive), .activeLevel(activeLevel),
    .vecAck(vecAck), .retiPulse(retiPulse),
    .strb(strb), .vecReq(vecReq), .vecAddr(vecAddr), .issuedLvl(issuedLvl)
  );
endmodule

// File: rtl/prio_irq_checker.sv
module prio_irq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       vecReq,
  input logic       vecAck,
  input logic       retiPulse,
  input logic [3:0] inService,
  input logic [1:0] activeLevel,
  input logic [1:0] issuedLvl,
  input logic       globalEn
);
  // R3: a vector only follows a cycle with the global gate open
  a_r3_global_gate: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |-> $past(globalEn));

  // R7: the strobe lasts one cycle
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |=> !vecReq);

  // R8: a new in-service bit only appears after an acknowledge
  a_r8_set_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    ((inService & ~$past(inService)) != 4'b0) |-> $past(vecAck));

  // R8: a return with no acknowledge removes exactly one level
  a_r8_pop_one: assert property (@(posedge clk) disable iff (!rstN)
    (retiPulse && !vecAck && (inService != 4'b0)) |=>
      ($countones(inService) + 1 == $countones($past(inService))));

  // R9: while nested, a vector is only issued for a strictly higher level
  a_r9_strict_preempt: assert property (@(posedge clk) disable iff (!rstN)
    (vecReq && $past(inService != 4'b0)) |-> (issuedLvl > $past(activeLevel)));
endmodule

bind prio_irq_ctrl prio_irq_checker uChk (
  .clk(clk), .rstN(rstN), .vecReq(vecReq), .vecAck(vecAck), .retiPulse(retiPulse),
  .inService(inService), .activeLevel(activeLevel), .issuedLvl(issuedLvl),
  .globalEn(globalEn)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] extInN = 2'b11;
  logic [1:0] extEdgeMode = 2'b00;
  logic [1:0] tmrOvf = 2'b00;
  logic       serReq = 1'b0, tmr2Req = 1'b0, pcaReq = 1'b0;
  logic       vecReq;
  logic [7:0] vecAddr;
  logic       vecAck = 1'b0, retiPulse = 1'b0;
  logic [3:0] inService;
  logic [1:0] activeLevel;
  logic [6:0] pendFlags;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .extInN(extInN),
    .extEdgeMode(extEdgeMode), .tmrOvf(tmrOvf), .serReq(serReq),
    .tmr2Req(tmr2Req), .pcaReq(pcaReq), .vecReq(vecReq), .vecAddr(vecAddr),
    .vecAck(vecAck), .retiPulse(retiPulse), .inService(inService),
    .activeLevel(activeLevel), .pendFlags(pendFlags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // Wait up to n cycles for a strobe; report the vector and confirm it is one cycle long
  task automatic expectVec(input string req, input logic [7:0] expVec);
    bit seen = 0;
    for (int i = 0; i < 12 && !seen; i++) begin
      @(negedge clk);
      if (vecReq) seen = 1;
    end
    check({req, " strobe seen"}, 32'(seen), 32'd1);
    check({req, " vector"}, 32'(vecAddr), 32'(expVec));
    @(negedge clk);
    check("R7 strobe one cycle", 32'(vecReq), 32'd0);
  endtask

  task automatic expectNoVec(input string req, input int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (vecReq) seen = 1;
    end
    check({req, " no strobe"}, 32'(seen), 32'd0);
  endtask

  task automatic ack();
    @(negedge clk); vecAck = 1'b1;
    @(negedge clk); vecAck = 1'b0;
  endtask

  task automatic retire();
    @(negedge clk); retiPulse = 1'b1;
    @(negedge clk); retiPulse = 1'b0;
  endtask

  task automatic clearRegs();
    wrReg(2'd0, 8'h00); wrReg(2'd1, 8'h00); wrReg(2'd2, 8'h00);
  endtask

  task automatic testReset();
    logic [7:0] d;
    for (int a = 0; a < 3; a++) begin
      rdReg(2'(a), d);
      check("R1 register reset", 32'(d), 32'd0);
    end
    check("R1 flags reset", 32'(pendFlags), 32'd0);
    check("R1 strobe reset", 32'(vecReq), 32'd0);
    check("R1 in-service reset", 32'(inService), 32'd0);
  endtask

  task automatic testRegs();
    logic [7:0] d;
    wrReg(2'd0, 8'h5A); wrReg(2'd1, 8'hFF); wrReg(2'd2, 8'h33); wrReg(2'd3, 8'hFF);
    rdReg(2'd0, d); check("R2 enable readback", 32'(d), 32'h5A);
    rdReg(2'd1, d); check("R2 low prio readback bit7 zero", 32'(d), 32'h7F);
    rdReg(2'd2, d); check("R2 high prio readback", 32'(d), 32'h33);
    rdReg(2'd3, d); check("R2 unused address", 32'(d), 32'h00);
    clearRegs();
  endtask

  task automatic testGating();
    wrReg(2'd0, 8'h02);
    @(negedge clk); tmrOvf[0] = 1'b1; @(negedge clk); tmrOvf[0] = 1'b0;
    expectNoVec("R3 global gate off", 10);
    check("R11 timer flag set", 32'(pendFlags[1]), 32'd1);
    wrReg(2'd0, 8'h82);
    expectVec("R6 timer 0", 8'h0B);
    ack();
    check("R11 timer flag hw cleared", 32'(pendFlags[1]), 32'd0);
    check("R8 ack sets level 0", 32'(inService), 32'h1);
    retire();
    check("R8 retire clears", 32'(inService), 32'h0);
    wrReg(2'd0, 8'h80);
    serReq = 1'b1;
    expectNoVec("R3 own enable off", 10);
    serReq = 1'b0;
    clearRegs();
  endtask

  task automatic testLevels();
    wrReg(2'd1, 8'h10); wrReg(2'd2, 8'h10);   // serial at level 3, external 0 at level 0
    extInN[0] = 1'b0; serReq = 1'b1;
    repeat (3) @(negedge clk);
    wrReg(2'd0, 8'h91);
    expectVec("R4 higher level beats poll order", 8'h23);
    ack();
    check("R8 level 3 in service", 32'(inService), 32'h8);
    check("R8 active level", 32'(activeLevel), 32'd3);
    expectNoVec("R9 lower level waits", 6);
    serReq = 1'b0;
    retire();
    expectVec("R6 external 0", 8'h03);
    ack();
    check("R10 level flag kept after ack", 32'(pendFlags[0]), 32'd1);
    extInN[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 level flag follows pin", 32'(pendFlags[0]), 32'd0);
    retire();
    clearRegs();
  endtask

  task automatic testTie();
    wrReg(2'd2, 8'h50);                        // serial and counter array at level 2
    serReq = 1'b1; pcaReq = 1'b1;
    repeat (2) @(negedge clk);
    wrReg(2'd0, 8'hD0);
    expectVec("R5 counter array before serial", 8'h33);
    ack();
    check("R8 level 2 in service", 32'(inService), 32'h4);
    expectNoVec("R9 equal level waits", 8);
    pcaReq = 1'b0;
    retire();
    expectVec("R6 serial", 8'h23);
    ack();
    check("R11 serial flag not hw cleared", 32'(pendFlags[4]), 32'd1);
    serReq = 1'b0;
    retire();
    clearRegs();
  endtask

  task automatic testNesting();
    extEdgeMode = 2'b10;
    wrReg(2'd1, 8'h0A);                        // timers 0 and 1 at level 1
    wrReg(2'd2, 8'h04);                        // external 1 at level 2
    wrReg(2'd0, 8'h8E);
    @(negedge clk); tmrOvf[1] = 1'b1; @(negedge clk); tmrOvf[1] = 1'b0;
    expectVec("R6 timer 1", 8'h1B);
    ack();
    check("R8 level 1 in service", 32'(inService), 32'h2);
    @(negedge clk); tmrOvf[0] = 1'b1; @(negedge clk); tmrOvf[0] = 1'b0;
    expectNoVec("R9 same level waits", 8);
    extInN[1] = 1'b0;
    expectVec("R9 higher level preempts", 8'h13);
    extInN[1] = 1'b1;
    ack();
    check("R8 nested levels", 32'(inService), 32'h6);
    check("R10 edge flag cleared on ack", 32'(pendFlags[2]), 32'd0);
    retire();
    check("R8 pop highest only", 32'(inService), 32'h2);
    expectNoVec("R9 still waiting after pop", 6);
    retire();
    expectVec("R9 resumes waiting timer 0", 8'h0B);
    ack(); retire();
    extEdgeMode = 2'b00;
    clearRegs();
  endtask

  task automatic testEdge();
    extEdgeMode = 2'b01;
    @(negedge clk); extInN[0] = 1'b0;
    repeat (2) @(negedge clk); extInN[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 edge flag held after pin high", 32'(pendFlags[0]), 32'd1);
    wrReg(2'd0, 8'h81);
    expectVec("R10 edge external 0", 8'h03);
    ack();
    check("R10 edge flag cleared", 32'(pendFlags[0]), 32'd0);
    expectNoVec("R10 no repeat after clear", 6);
    retire();
    extEdgeMode = 2'b00;
    clearRegs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testGating();
    testLevels();
    testTie();
    testNesting();
    testEdge();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule